// File: doc/BRIEF.md
# Neutral-Point Balancing Offset Estimator

This block keeps the two halves of a three-level inverter's split DC link at equal voltage. It produces one signed time offset, counted in modulator timer ticks. The modulator adds this offset to all three phase turn-on compare times. A negative offset lengthens the dwell of the small vectors that charge the neutral point. A positive offset lengthens the dwell of the small vectors that discharge it.

A base control tick (`tick_i`) marks each new imbalance sample `vd_i`. The sample is the upper capacitor voltage minus the lower one, as a signed fixed-point value. With the default parameters one LSB is 1/16 V, so 1 V = 16, 3 V = 48 and 10 V = 160. A decision is made only on some ticks. On those ticks the block compares the new sample with the sample from the previous decision. From that comparison it either moves the offset by one step, holds it, or forces it to full scale. It then presents the saturated result together with a one-cycle strobe. The time between decisions and the step size both depend on how large the imbalance is: large errors get short periods and coarse steps, and small errors get long periods and fine steps.

Top module: `np_offset_estimator`

## Requirements
- R1: While `rst_ni` is low and after it is released, `offset_o` reads 0 and `upd_o` reads 0 until the first decision. The period count and the stored previous sample also restart from zero.
- R2: The block counts ticks since the previous decision, including the current tick. A decision is made on the tick at which this count reaches the period chosen by that tick's sample: 5 ticks when |vd_i| > 48, otherwise 20 ticks. The result appears one clock after the tick, and `upd_o` is high for exactly that one clock.
- R3: `offset_o` changes only in a cycle where `upd_o` is high.
- R4: If |vd_i| > 160 on a decision, the offset becomes -1150 when vd_i > 0 and +1150 when vd_i < 0.
- R5: If |vd_i| < 16 on a decision, the offset keeps its previous value.
- R6: In the stepping band (16 <= |vd_i| <= 160), the step is 30 ticks when |vd_i| > 48 and 1 tick otherwise.
- R7: In the stepping band, a negative sample with an offset >= 0 adds one step, and a positive sample with an offset <= 0 subtracts one step.
- R8: Overshoot correction: with offset > 0, a positive sample greater than the previous decision's sample subtracts one step. With offset < 0, a negative sample smaller than the previous one adds one step.
- R9: With offset > 0, a positive sample that is not greater than the previous one holds the offset. With offset < 0, a negative sample that is not smaller than the previous one holds the offset.
- R10: After every step the offset is clamped to the range -1150 to +1150.
- R11: The previous sample is replaced on every decision, including forced and balanced decisions, and only on decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base control tick, one cycle wide; qualifies `vd_i` |
| vd_i | input | 16 | Signed imbalance sample, upper minus lower capacitor voltage |
| offset_o | output | 12 | Signed turn-on time offset in timer ticks |
| upd_o | output | 1 | One-cycle strobe marking a new decision |

## Verification
The in-line properties check on every cycle that the offset moves only with the strobe, stays inside full scale, and changes by at most one fine step in the fine band. They also check that it lands on the correct full-scale value in a forced decision, that it holds in a balanced one, and that the strobe never lasts two cycles. Only the bench scenarios can show that the period counting is correct when the band changes partway through a period. The same applies to whether the step direction follows the overshoot rules, which depend on the history of samples, and whether the stored previous sample is refreshed by balanced decisions. The bench drives all of these through sweeps and targeted sequences against an arithmetic model.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;
  typedef enum logic [1:0] {
    Z_BAL    = 2'd0,
    Z_FINE   = 2'd1,
    Z_COARSE = 2'd2,
    Z_SAT    = 2'd3
  } zone_e;
endpackage

// File: rtl/np_zone_classify.sv
module np_zone_classify
  import np_bal_pkg::*;
#(
  parameter int VD_W   = 16,
  parameter int TH_BAL = 16,
  parameter int TH_MIN = 48,
  parameter int TH_MAX = 160
) (
  input  logic signed [VD_W-1:0] vd_i,
  output zone_e                  zone_o,
  output logic                   neg_o,
  output logic                   fast_o
);
  localparam int MW = VD_W + 1;
  localparam logic [MW-1:0] BAL_L = MW'(TH_BAL);
  localparam logic [MW-1:0] MIN_L = MW'(TH_MIN);
  localparam logic [MW-1:0] MAX_L = MW'(TH_MAX);

  logic signed [MW-1:0] ext;
  logic        [MW-1:0] mag;

  always_comb begin
    ext   = MW'(vd_i);
    mag   = ext[MW-1] ? unsigned'(-ext) : unsigned'(ext);
    neg_o = vd_i[VD_W-1];
    if (mag > MAX_L)       zone_o = Z_SAT;
    else if (mag > MIN_L)  zone_o = Z_COARSE;
    else if (mag >= BAL_L) zone_o = Z_FINE;
    else                   zone_o = Z_BAL;
    fast_o = (mag > MIN_L);
  end
endmodule

// File: rtl/np_rate_ctrl.sv
module np_rate_ctrl #(
  parameter int DIV_FAST = 5,
  parameter int DIV_SLOW = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  output logic dec_o
);
  localparam int CNT_W = $clog2(DIV_SLOW + 1);
  localparam logic [CNT_W-1:0] FAST_L = CNT_W'(DIV_FAST);
  localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q, cnt_inc, period;

  always_comb begin
    period  = fast_i ? FAST_L : SLOW_L;
    cnt_inc = cnt_q + CNT_W'(1);
    // a shorter period picked mid-count fires at once
    dec_o   = tick_i && (cnt_inc >= period);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (dec_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_inc;
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < SLOW_L);

  p_cnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/np_offset_step.sv
module np_offset_step
  import np_bal_pkg::*;
#(
  parameter int VD_W        = 16,
  parameter int OFS_W       = 12,
  parameter int OFS_MAX     = 1150,
  parameter int STEP_COARSE = 30,
  parameter int STEP_FINE   = 1
) (
  input  zone_e                   zone_i,
  input  logic                    neg_i,
  input  logic signed [VD_W-1:0]  vd_i,
  input  logic signed [VD_W-1:0]  vd_old_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  output logic signed [OFS_W-1:0] ofs_o
);
  localparam int SW = OFS_W + 1;
  localparam logic signed [SW-1:0] MAX_S = SW'(OFS_MAX);
  localparam logic signed [SW-1:0] MIN_S = -SW'(OFS_MAX);

  logic signed [SW-1:0] step, raw, base;
  logic                 up, dn;

  always_comb begin
    base = SW'(ofs_i);
    step = (zone_i == Z_COARSE) ? SW'(STEP_COARSE) : SW'(STEP_FINE);
    up   = 1'b0;
    dn   = 1'b0;
    if (ofs_i > 0) begin
      if (neg_i)              up = 1'b1;
      else if (vd_i > vd_old_i) dn = 1'b1;   // overshoot past the correct value
    end else if (ofs_i < 0) begin
      if (!neg_i)             dn = 1'b1;
      else if (vd_i < vd_old_i) up = 1'b1;
    end else begin
      up = neg_i;
      dn = !neg_i;
    end
    raw = base;
    if (up)      raw = base + step;
    else if (dn) raw = base - step;
    if (raw > MAX_S)      raw = MAX_S;
    else if (raw < MIN_S) raw = MIN_S;

    unique case (zone_i)
      Z_SAT:   ofs_o = neg_i ? OFS_W'(OFS_MAX) : -OFS_W'(OFS_MAX);
      Z_BAL:   ofs_o = ofs_i;
      default: ofs_o = raw[OFS_W-1:0];
    endcase
  end
endmodule

// File: rtl/np_offset_estimator.sv
module np_offset_estimator
  import np_bal_pkg::*;
#(
  parameter int VD_W        = 16,
  parameter int OFS_W       = 12,
  parameter int OFS_MAX     = 1150,
  parameter int TH_BAL      = 16,
  parameter int TH_MIN      = 48,
  parameter int TH_MAX      = 160,
  parameter int STEP_COARSE = 30,
  parameter int STEP_FINE   = 1,
  parameter int DIV_FAST    = 5,   // must be >= 2
  parameter int DIV_SLOW    = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [VD_W-1:0]  vd_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    upd_o
);
  localparam logic signed [OFS_W-1:0] MAX_O = OFS_W'(OFS_MAX);

  zone_e                   zone;
  logic                    neg, fast, dec;
  logic signed [VD_W-1:0]  vd_old_q;
  logic signed [OFS_W-1:0] ofs_q, ofs_nxt;
  logic                    upd_q;

  np_zone_classify #(
    .VD_W(VD_W), .TH_BAL(TH_BAL), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX)
  ) i_classify (
    .vd_i(vd_i), .zone_o(zone), .neg_o(neg), .fast_o(fast)
  );

  np_rate_ctrl #(
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
  ) i_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .fast_i(fast), .dec_o(dec)
  );

  np_offset_step #(
    .VD_W(VD_W), .OFS_W(OFS_W), .OFS_MAX(OFS_MAX),
    .STEP_COARSE(STEP_COARSE), .STEP_FINE(STEP_FINE)
  ) i_step (
    .zone_i(zone), .neg_i(neg), .vd_i(vd_i), .vd_old_i(vd_old_q),
    .ofs_i(ofs_q), .ofs_o(ofs_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q    <= '0;
      vd_old_q <= '0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= dec;
      if (dec) begin
        ofs_q    <= ofs_nxt;
        vd_old_q <= vd_i;
      end
    end
  end

  assign offset_o = ofs_q;
  assign upd_o    = upd_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(ofs_q));

  p_one_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);

  p_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && zone == Z_SAT) |=> (ofs_q == ($past(neg) ? MAX_O : -MAX_O)));

  p_balanced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && zone == Z_BAL) |=> $stable(ofs_q));

  p_fine_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && zone == Z_FINE) |=>
      ((ofs_q - $past(ofs_q) <= OFS_W'(STEP_FINE)) &&
       ($past(ofs_q) - ofs_q <= OFS_W'(STEP_FINE))));

  p_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_q <= MAX_O) && (ofs_q >= -MAX_O));

  p_old_track_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec |=> $stable(vd_old_q));
endmodule

// File: tb/test_np_offset_estimator.sv
`timescale 1ns/1ps
module test_np_offset_estimator;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               tick_i = 1'b0;
  logic signed [15:0] vd_i = '0;
  logic signed [11:0] offset_o;
  logic               upd_o;

  int errors = 0;
  int checks = 0;
  // bench model state
  int m_ofs = 0, m_old = 0, m_cnt = 0;

  always #4 clk_i = ~clk_i;

  np_offset_estimator i_np_offset_estimator (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .vd_i(vd_i),
    .offset_o(offset_o), .upd_o(upd_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0;
    @(negedge clk_i);
    check(offset_o == 0, "R1 offset in reset", offset_o, 0);
    check(upd_o == 0, "R1 strobe in reset", upd_o, 0);
    rst_ni = 1'b1;
    m_ofs = 0; m_old = 0; m_cnt = 0;
    @(negedge clk_i);
    check(offset_o == 0 && upd_o == 0, "R1 after release", offset_o, 0);
  endtask

  // one tick with sample v; model computed from the requirements
  task automatic do_tick(input int v);
    int    mag, per, exp_ofs, step, prev;
    bit    dec;
    string tag;
    mag = (v < 0) ? -v : v;
    per = (mag > 48) ? 5 : 20;
    dec = (m_cnt + 1 >= per);
    tag = "R2";
    exp_ofs = m_ofs;
    if (dec) begin
      m_cnt = 0;
      step = (mag > 48) ? 30 : 1;
      if (mag > 160) begin
        exp_ofs = (v > 0) ? -1150 : 1150; tag = "R4";
      end else if (mag < 16) begin
        tag = "R5 R11";
      end else begin
        tag = "R6 R7";
        if (m_ofs > 0) begin
          if (v < 0) exp_ofs = m_ofs + step;
          else if (v > m_old) begin exp_ofs = m_ofs - step; tag = "R6 R8 R11"; end
          else tag = "R9 R11";
        end else if (m_ofs < 0) begin
          if (v > 0) exp_ofs = m_ofs - step;
          else if (v < m_old) begin exp_ofs = m_ofs + step; tag = "R6 R8 R11"; end
          else tag = "R9 R11";
        end else exp_ofs = (v < 0) ? step : -step;
        if (exp_ofs > 1150) begin exp_ofs = 1150; tag = "R10"; end
        if (exp_ofs < -1150) begin exp_ofs = -1150; tag = "R10"; end
      end
      m_old = v;
    end else m_cnt++;
    prev = m_ofs;
    m_ofs = exp_ofs;
    @(negedge clk_i);
    vd_i = 16'(v);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    vd_i = 16'sh7abc;  // ignored between ticks
    check(upd_o == dec, "R2 strobe", upd_o, dec);
    check(offset_o == exp_ofs, tag, offset_o, exp_ofs);
    @(negedge clk_i);
    check(upd_o == 0, "R2 single pulse", upd_o, 0);
    check(offset_o == exp_ofs, "R3 hold between decisions", offset_o, exp_ofs);
    if (!dec) check(offset_o == prev, "R3 no decision", offset_o, prev);
  endtask

  task automatic hold(input int v, input int n);
    for (int k = 0; k < n; k++) do_tick(v);
  endtask

  initial begin
    do_reset();
    // zero offset start: first decision after 20 slow ticks
    hold(-30, 20);
    hold(30, 20);
    // sweep across fine and balanced bands
    for (int v = -45; v <= 45; v += 5) hold(v, 20);
    // forced negative then overshoot in negative branch
    hold(200, 5);
    hold(100, 10);
    hold(-20, 20);
    hold(-25, 20);
    hold(-22, 20);
    // forced positive, clamp, overshoot, hold
    hold(-200, 5);
    hold(-100, 5);
    hold(60, 5);
    hold(60, 5);
    hold(50, 5);
    hold(70, 5);
    // balanced decision refreshes the previous sample
    hold(10, 20);
    hold(30, 20);
    // reset mid run, then cadence switching sweep
    hold(-100, 3);
    do_reset();
    for (int v = -250; v <= 250; v += 11) hold(v, 7);
    for (int v = 250; v >= -250; v -= 13) hold(v, 9);
    hold(20, 13);
    hold(90, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule